// File: doc/BRIEF.md
# Banked Stack Pointer CSR Unit

This block keeps the pointer, base and limit registers of three hardware stacks, one for each privilege level: user, supervisor and machine. It also serves a read-only feature word that describes the stack hardware. Three paths reach the registers. The first is a CSR port keyed by a 12-bit address. The second is an atomic pointer-swap port, used for coroutine and context switches. The third is a shortcut port for the single-register get and set instructions. Every access is checked against the current privilege level, and a refused access raises a fault flag.

Reads and fault flags are combinational: they reflect the request and the register state of the same cycle. Writes take effect at the next rising clock edge. Each stack grows downward. Its base register holds the highest valid address plus 8, and its limit register holds the lowest valid address. Reset empties every stack by loading its pointer with its base. The stack RAM, the push/pop sequencing and trap delivery are outside this block.

Top module: `sbk_csr_unit`

## Requirements
- R1: After a synchronous reset, each pointer equals its base. Each base equals the region start plus the stack size in KiB times 1024, and each limit equals the region start. The defaults are user 0xE000_0000/64 KiB, supervisor 0xE001_0000/32 KiB and machine 0xE001_8000/16 KiB.
- R2: CSR addresses 0x800/0x801/0x802 select the user pointer, base and limit. Addresses 0x900–0x902 select the supervisor triple and 0xBC0–0xBC2 select the machine triple. An accepted request returns the selected register on `csr_rdata_o` in the same cycle.
- R3: The privilege codes are 2'b00 user, 2'b01 supervisor and 2'b11 machine; 2'b10 counts as user. User registers are accessible from any level, supervisor registers need supervisor or machine, and machine registers need machine. A refused access raises `csr_fault_o`, returns zero data and writes nothing.
- R4: Address 0xFC2 reads the feature word in machine mode only. Its fields are: bit 0 = 1 (present); bits 7:1 = 1 (version); bits 11:8 = log2 of dwords per cycle (default 2); bits 19:12, 27:20 and 33:28 = user, supervisor and machine size in KiB; bit 34 = wide register-list flag (default 1); bits 63:35 = 0.
- R5: A write to 0xFC2 faults at every privilege level, and the feature word stays unchanged.
- R6: Any other address faults and returns zero.
- R7: A swap returns the old pointer on `swap_old_o` in the request cycle and installs `swap_new_i` at the next edge. `swap_sup_i` = 0 selects the user stack and 1 selects the supervisor stack.
- R8: A supervisor swap in user mode raises `swap_fault_o`, returns zero and leaves the pointer unchanged.
- R9: Shortcut operations on `sc_op_i` are 0 get pointer, 1 set pointer, 2 get base and 3 get limit. `sc_sup_i` selects the supervisor stack (1) or the user stack (0). Supervisor shortcuts fault in user mode and return zero. A set returns zero data.
- R10: When writes target the same pointer in one cycle, the swap has priority over a shortcut set, and a shortcut set has priority over a CSR write.
- R11: A CSR write shows on reads from the next cycle on. A read in the write's own cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege level |
| csr_req_i | input | 1 | CSR access request |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data (old value during a write) |
| csr_fault_o | output | 1 | CSR access refused |
| swap_req_i | input | 1 | Pointer swap request |
| swap_sup_i | input | 1 | Swap targets supervisor stack |
| swap_new_i | input | 64 | New pointer value |
| swap_old_o | output | 64 | Previous pointer value |
| swap_fault_o | output | 1 | Swap refused |
| sc_req_i | input | 1 | Shortcut request |
| sc_sup_i | input | 1 | Shortcut targets supervisor stack |
| sc_op_i | input | 2 | Shortcut operation |
| sc_wdata_i | input | 64 | Shortcut set value |
| sc_rdata_o | output | 64 | Shortcut read data |
| sc_fault_o | output | 1 | Shortcut refused |

## Verification
Read data, swap old values and all three fault flags are due in the cycle of the request. A write, swap or set becomes visible in the cycle after its edge. Each expected item in the scoreboard carries the cycle number in which it is due. The bench drives just after a rising edge and compares at the following falling edge, so each result is checked in its own cycle. State effects, including those of refused or colliding writes, are checked by a read in the next cycle.

// File: rtl/sbk_pkg.sv
package sbk_pkg;

    localparam int XLEN      = 64;
    localparam int NUM_BANKS = 3;

    localparam logic [11:0] ADDR_FEATURE = 12'hFC2;

    typedef enum logic [1:0] {
        BANK_U = 2'd0,
        BANK_S = 2'd1,
        BANK_M = 2'd2
    } bank_e;

    // low two address bits select the register inside a bank
    typedef enum logic [1:0] {
        FLD_PTR   = 2'd0,
        FLD_BASE  = 2'd1,
        FLD_LIMIT = 2'd2
    } field_e;

    typedef enum logic [1:0] {
        SC_GET_PTR   = 2'd0,
        SC_SET_PTR   = 2'd1,
        SC_GET_BASE  = 2'd2,
        SC_GET_LIMIT = 2'd3
    } sc_op_e;

    typedef struct packed {
        logic   mapped;
        logic   is_feature;
        bank_e  bank;
        field_e field;
    } csr_sel_t;

    // privilege code to rank: 00 user, 01 supervisor, 11 machine, 10 as user
    function automatic logic [1:0] priv_rank(input logic [1:0] p);
        case (p)
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // address bits 11:2 of each bank's window
    function automatic logic [9:0] bank_prefix(input int b);
        case (b)
            0:       return 10'h200;
            1:       return 10'h240;
            default: return 10'h2F0;
        endcase
    endfunction

endpackage

// File: rtl/sbk_decode.sv
module sbk_decode
    import sbk_pkg::*;
(
    input  logic [11:0] addr_i,
    input  logic [1:0]  priv_i,
    output csr_sel_t    sel_o,
    output logic        allowed_o
);

    always_comb begin
        sel_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_i[11:2] == bank_prefix(b) && addr_i[1:0] != 2'd3) begin
                sel_o.mapped = 1'b1;
                sel_o.bank   = bank_e'(b);
                sel_o.field  = field_e'(addr_i[1:0]);
            end
        end
        if (addr_i == ADDR_FEATURE) begin
            sel_o.mapped     = 1'b1;
            sel_o.is_feature = 1'b1;
        end
    end

    always_comb begin
        if (!sel_o.mapped)
            allowed_o = 1'b0;
        else if (sel_o.is_feature)
            allowed_o = (priv_rank(priv_i) == 2'd2);
        else
            allowed_o = (priv_rank(priv_i) >= sel_o.bank);
    end

endmodule

// File: rtl/sbk_bank.sv
module sbk_bank
    import sbk_pkg::*;
#(
    parameter logic [XLEN-1:0] RST_BASE  = '0,
    parameter logic [XLEN-1:0] RST_LIMIT = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_we_i,
    input  field_e          csr_field_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    input  logic            sc_set_i,
    input  logic [XLEN-1:0] sc_wdata_i,
    input  logic            swap_en_i,
    input  logic [XLEN-1:0] swap_val_i,
    output logic [XLEN-1:0] ptr_o,
    output logic [XLEN-1:0] base_o,
    output logic [XLEN-1:0] limit_o
);

    logic [XLEN-1:0] ptr_q, base_q, lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= RST_BASE;
            base_q <= RST_BASE;
            lim_q  <= RST_LIMIT;
        end else begin
            if (csr_we_i && csr_field_i == FLD_BASE)  base_q <= csr_wdata_i;
            if (csr_we_i && csr_field_i == FLD_LIMIT) lim_q  <= csr_wdata_i;
            if (swap_en_i)
                ptr_q <= swap_val_i;
            else if (sc_set_i)
                ptr_q <= sc_wdata_i;
            else if (csr_we_i && csr_field_i == FLD_PTR)
                ptr_q <= csr_wdata_i;
        end
    end

    assign ptr_o   = ptr_q;
    assign base_o  = base_q;
    assign limit_o = lim_q;

    // R10: swap value is what lands, whatever else was requested
    a_r10_swap_wins: assert property (@(posedge clk) disable iff (rst)
        swap_en_i |=> ptr_q == $past(swap_val_i));

    // R11: no enable means no state change
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !(csr_we_i || sc_set_i || swap_en_i) |=>
            ($stable(ptr_q) && $stable(base_q) && $stable(lim_q)));

endmodule

// File: rtl/sbk_csr_unit.sv
module sbk_csr_unit
    import sbk_pkg::*;
#(
    parameter int              U_KIB      = 64,
    parameter int              S_KIB      = 32,
    parameter int              M_KIB      = 16,
    parameter logic [XLEN-1:0] U_REGION   = 64'hE000_0000,
    parameter logic [XLEN-1:0] S_REGION   = 64'hE001_0000,
    parameter logic [XLEN-1:0] M_REGION   = 64'hE001_8000,
    parameter int              PORT_LOG2  = 2,
    parameter bit              WIDE_RLIST = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  priv_i,
    input  logic        csr_req_i,
    input  logic        csr_we_i,
    input  logic [11:0] csr_addr_i,
    input  logic [63:0] csr_wdata_i,
    output logic [63:0] csr_rdata_o,
    output logic        csr_fault_o,
    input  logic        swap_req_i,
    input  logic        swap_sup_i,
    input  logic [63:0] swap_new_i,
    output logic [63:0] swap_old_o,
    output logic        swap_fault_o,
    input  logic        sc_req_i,
    input  logic        sc_sup_i,
    input  logic [1:0]  sc_op_i,
    input  logic [63:0] sc_wdata_i,
    output logic [63:0] sc_rdata_o,
    output logic        sc_fault_o
);

    localparam logic [XLEN-1:0] RST_LIMIT [NUM_BANKS] = '{U_REGION, S_REGION, M_REGION};
    localparam logic [XLEN-1:0] RST_BASE  [NUM_BANKS] = '{
        U_REGION + 64'(U_KIB) * 64'd1024,
        S_REGION + 64'(S_KIB) * 64'd1024,
        M_REGION + 64'(M_KIB) * 64'd1024};

    localparam logic [XLEN-1:0] FEATURE = {29'd0, WIDE_RLIST, 6'(M_KIB), 8'(S_KIB),
                                           8'(U_KIB), 4'(PORT_LOG2), 7'd1, 1'b1};

    csr_sel_t        sel;
    logic            allowed;
    logic            user_only;
    sc_op_e          sc_op;
    logic [XLEN-1:0] ptr_a  [NUM_BANKS];
    logic [XLEN-1:0] base_a [NUM_BANKS];
    logic [XLEN-1:0] lim_a  [NUM_BANKS];
    logic [XLEN-1:0] bank_field;

    sbk_decode u_decode (
        .addr_i    (csr_addr_i),
        .priv_i    (priv_i),
        .sel_o     (sel),
        .allowed_o (allowed)
    );

    assign user_only    = (priv_rank(priv_i) == 2'd0);
    assign sc_op        = sc_op_e'(sc_op_i);
    assign csr_fault_o  = csr_req_i && (!allowed || (csr_we_i && sel.is_feature));
    assign swap_fault_o = swap_req_i && swap_sup_i && user_only;
    assign sc_fault_o   = sc_req_i && sc_sup_i && user_only;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic csr_we_b, sc_set_b, swap_en_b;
        if (b < 2) begin : g_swappable
            assign swap_en_b = swap_req_i && !swap_fault_o && (swap_sup_i == (b == 1));
            assign sc_set_b  = sc_req_i && !sc_fault_o && sc_op == SC_SET_PTR
                               && (sc_sup_i == (b == 1));
        end else begin : g_fixed
            assign swap_en_b = 1'b0;
            assign sc_set_b  = 1'b0;
        end
        assign csr_we_b = csr_req_i && csr_we_i && !csr_fault_o && !sel.is_feature
                          && sel.bank == bank_e'(b);

        sbk_bank #(
            .RST_BASE  (RST_BASE[b]),
            .RST_LIMIT (RST_LIMIT[b])
        ) u_bank (
            .clk         (clk),
            .rst         (rst),
            .csr_we_i    (csr_we_b),
            .csr_field_i (sel.field),
            .csr_wdata_i (csr_wdata_i),
            .sc_set_i    (sc_set_b),
            .sc_wdata_i  (sc_wdata_i),
            .swap_en_i   (swap_en_b),
            .swap_val_i  (swap_new_i),
            .ptr_o       (ptr_a[b]),
            .base_o      (base_a[b]),
            .limit_o     (lim_a[b])
        );
    end

    always_comb begin
        case (sel.field)
            FLD_PTR:   bank_field = ptr_a[sel.bank];
            FLD_BASE:  bank_field = base_a[sel.bank];
            FLD_LIMIT: bank_field = lim_a[sel.bank];
            default:   bank_field = '0;
        endcase
    end

    assign csr_rdata_o = (!csr_req_i || csr_fault_o) ? '0 :
                         sel.is_feature ? FEATURE : bank_field;

    assign swap_old_o = (swap_req_i && !swap_fault_o) ? ptr_a[swap_sup_i ? 1 : 0] : '0;

    always_comb begin
        sc_rdata_o = '0;
        if (sc_req_i && !sc_fault_o) begin
            case (sc_op)
                SC_GET_PTR:   sc_rdata_o = ptr_a[sc_sup_i ? 1 : 0];
                SC_GET_BASE:  sc_rdata_o = base_a[sc_sup_i ? 1 : 0];
                SC_GET_LIMIT: sc_rdata_o = lim_a[sc_sup_i ? 1 : 0];
                default:      sc_rdata_o = '0;
            endcase
        end
    end

    // R3: a refused CSR access returns no data
    a_r3_fault_blanks_data: assert property (@(posedge clk) disable iff (rst)
        csr_fault_o |-> csr_rdata_o == '0);

    // R5: the feature word never takes a write
    a_r5_feature_write_faults: assert property (@(posedge clk) disable iff (rst)
        (csr_req_i && csr_we_i && csr_addr_i == 12'hFC2) |-> csr_fault_o);

    // R8: supervisor swap from user mode is refused and leaves the pointer
    a_r8_sup_swap_user_faults: assert property (@(posedge clk) disable iff (rst)
        (swap_req_i && swap_sup_i && priv_i == 2'b00 && !sc_req_i && !csr_req_i)
            |=> $stable(ptr_a[1]));

    // R9: supervisor shortcut from user mode is refused
    a_r9_sup_shortcut_user_faults: assert property (@(posedge clk) disable iff (rst)
        (sc_req_i && sc_sup_i && priv_i == 2'b00) |-> (sc_fault_o && sc_rdata_o == '0));

endmodule

// File: tb/sbk_csr_unit_test.sv
module sbk_csr_unit_test;

    localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;
    localparam logic [63:0] UB = 64'hE001_0000, UL = 64'hE000_0000;
    localparam logic [63:0] SB = 64'hE001_8000, SL = 64'hE001_0000;
    localparam logic [63:0] MB = 64'hE001_C000, ML = 64'hE001_8000;
    localparam logic [63:0] FEAT = 64'd1 | (64'd1 << 1) | (64'd2 << 8) | (64'd64 << 12)
                                 | (64'd32 << 20) | (64'd16 << 28) | (64'd1 << 34);
    localparam int O_CRD = 0, O_CF = 1, O_SWO = 2, O_SWF = 3, O_SCD = 4, O_SCF = 5;

    logic        clk = 1'b0, rst = 1'b1;
    logic [1:0]  priv_i = PM;
    logic        csr_req_i = 0, csr_we_i = 0;
    logic [11:0] csr_addr_i = '0;
    logic [63:0] csr_wdata_i = '0, csr_rdata_o;
    logic        csr_fault_o;
    logic        swap_req_i = 0, swap_sup_i = 0;
    logic [63:0] swap_new_i = '0, swap_old_o;
    logic        swap_fault_o;
    logic        sc_req_i = 0, sc_sup_i = 0;
    logic [1:0]  sc_op_i = '0;
    logic [63:0] sc_wdata_i = '0, sc_rdata_o;
    logic        sc_fault_o;

    sbk_csr_unit uut (.*);

    always #2 clk = ~clk;

    typedef struct {
        int          cyc;
        int          sel;
        logic [63:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0, checks = 0, fails = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] pick(input int s);
        case (s)
            O_CRD:   return csr_rdata_o;
            O_CF:    return {63'd0, csr_fault_o};
            O_SWO:   return swap_old_o;
            O_SWF:   return {63'd0, swap_fault_o};
            O_SCD:   return sc_rdata_o;
            default: return {63'd0, sc_fault_o};
        endcase
    endfunction

    // monitor: compare every item due in this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (pick(it.sel) !== it.val) begin
                fails++;
                $display("FAIL %s: output %0d got %h expected %h", it.tag, it.sel,
                         pick(it.sel), it.val);
            end
        end
    end

    task automatic want(input int s, input logic [63:0] v, input string tag);
        item_t it;
        it.cyc = cyc; it.sel = s; it.val = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic next_cycle();
        @(posedge clk); #1;
        csr_req_i = 0; csr_we_i = 0; swap_req_i = 0; sc_req_i = 0; rst = 0;
    endtask

    task automatic csr(input logic [1:0] p, input logic we, input logic [11:0] a,
                       input logic [63:0] d);
        next_cycle();
        priv_i = p; csr_req_i = 1; csr_we_i = we; csr_addr_i = a; csr_wdata_i = d;
    endtask

    task automatic csr_read(input logic [1:0] p, input logic [11:0] a,
                            input logic [63:0] v, input string tag);
        csr(p, 1'b0, a, '0);
        want(O_CRD, v, tag);
        want(O_CF, 64'd0, tag);
    endtask

    task automatic swap(input logic [1:0] p, input logic s, input logic [63:0] n);
        next_cycle();
        priv_i = p; swap_req_i = 1; swap_sup_i = s; swap_new_i = n;
    endtask

    task automatic sc(input logic [1:0] p, input logic s, input logic [1:0] op,
                      input logic [63:0] d);
        next_cycle();
        priv_i = p; sc_req_i = 1; sc_sup_i = s; sc_op_i = op; sc_wdata_i = d;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R1 and R2: reset values through the whole address map
        csr_read(PM, 12'h800, UB, "R1 user ptr");
        csr_read(PM, 12'h801, UB, "R2 user base");
        csr_read(PM, 12'h802, UL, "R2 user limit");
        csr_read(PM, 12'h900, SB, "R1 sup ptr");
        csr_read(PM, 12'h901, SB, "R2 sup base");
        csr_read(PM, 12'h902, SL, "R2 sup limit");
        csr_read(PM, 12'hBC0, MB, "R1 mach ptr");
        csr_read(PM, 12'hBC1, MB, "R2 mach base");
        csr_read(PM, 12'hBC2, ML, "R2 mach limit");
        // R4: feature word, machine only
        csr_read(PM, 12'hFC2, FEAT, "R4 feature");
        csr(PS, 0, 12'hFC2, '0); want(O_CF, 1, "R4 feature in S"); want(O_CRD, 0, "R4 feature in S");
        // R5: write to feature word
        csr(PM, 1, 12'hFC2, 64'hDEAD); want(O_CF, 1, "R5 feature write"); want(O_CRD, 0, "R5 feature write");
        csr_read(PM, 12'hFC2, FEAT, "R5 feature unchanged");
        // R6: unmapped addresses
        csr(PM, 0, 12'h803, '0); want(O_CF, 1, "R6 0x803"); want(O_CRD, 0, "R6 0x803");
        csr(PM, 0, 12'hBC3, '0); want(O_CF, 1, "R6 0xBC3");
        csr(PM, 0, 12'h123, '0); want(O_CF, 1, "R6 0x123");
        // R3: privilege rules
        csr(PU, 1, 12'h900, 64'h1111); want(O_CF, 1, "R3 user writes sup"); want(O_CRD, 0, "R3 user writes sup");
        csr_read(PM, 12'h900, SB, "R3 sup ptr untouched");
        csr(PS, 0, 12'hBC0, '0); want(O_CF, 1, "R3 sup reads mach");
        csr(2'b10, 0, 12'h901, '0); want(O_CF, 1, "R3 code 10 as user");
        csr(PS, 1, 12'h902, 64'hE001_0100); want(O_CF, 0, "R3 sup writes sup limit");
        csr_read(PS, 12'h902, 64'hE001_0100, "R3 sup limit written");
        // R11: write is visible next cycle, old value same cycle
        csr(PU, 1, 12'h800, 64'hE000_8000); want(O_CF, 0, "R3 user writes user");
        want(O_CRD, UB, "R11 old value in write cycle");
        csr_read(PU, 12'h800, 64'hE000_8000, "R11 new value next cycle");
        // R7: user swap
        swap(PU, 0, 64'hE000_4000); want(O_SWO, 64'hE000_8000, "R7 swap old"); want(O_SWF, 0, "R7 swap ok");
        csr_read(PU, 12'h800, 64'hE000_4000, "R7 swap installed");
        // R8: supervisor swap in user mode
        swap(PU, 1, 64'h5555); want(O_SWF, 1, "R8 sup swap user"); want(O_SWO, 0, "R8 sup swap user");
        csr_read(PM, 12'h900, SB, "R8 sup ptr unchanged");
        swap(PS, 1, 64'hE001_7000); want(O_SWO, SB, "R7 sup swap old"); want(O_SWF, 0, "R7 sup swap ok");
        csr_read(PM, 12'h900, 64'hE001_7000, "R7 sup swap installed");
        // R9: shortcuts
        sc(PU, 0, 2'd0, '0); want(O_SCD, 64'hE000_4000, "R9 get user ptr"); want(O_SCF, 0, "R9 get user ptr");
        sc(PU, 0, 2'd1, 64'hE000_2000); want(O_SCD, 0, "R9 set data zero"); want(O_SCF, 0, "R9 set ok");
        sc(PU, 0, 2'd0, '0); want(O_SCD, 64'hE000_2000, "R9 set took effect");
        sc(PU, 1, 2'd2, '0); want(O_SCF, 1, "R9 sup shortcut in user"); want(O_SCD, 0, "R9 sup shortcut in user");
        sc(PU, 1, 2'd1, 64'h7777); want(O_SCF, 1, "R9 sup set in user");
        sc(PS, 1, 2'd0, '0); want(O_SCD, 64'hE001_7000, "R9 sup set refused");
        sc(PS, 1, 2'd3, '0); want(O_SCD, 64'hE001_0100, "R9 sup get limit");
        sc(PS, 0, 2'd2, '0); want(O_SCD, UB, "R9 user get base");
        // R10: collisions on the user pointer
        next_cycle();
        priv_i = PM;
        swap_req_i = 1; swap_sup_i = 0; swap_new_i = 64'hE000_A000;
        sc_req_i = 1; sc_sup_i = 0; sc_op_i = 2'd1; sc_wdata_i = 64'hE000_B000;
        csr_req_i = 1; csr_we_i = 1; csr_addr_i = 12'h800; csr_wdata_i = 64'hE000_C000;
        want(O_SWO, 64'hE000_2000, "R10 swap old in collision");
        csr_read(PM, 12'h800, 64'hE000_A000, "R10 swap wins");
        next_cycle();
        priv_i = PM;
        sc_req_i = 1; sc_sup_i = 0; sc_op_i = 2'd1; sc_wdata_i = 64'hE000_B000;
        csr_req_i = 1; csr_we_i = 1; csr_addr_i = 12'h800; csr_wdata_i = 64'hE000_C000;
        csr_read(PM, 12'h800, 64'hE000_B000, "R10 set beats CSR write");
        // R1: reset again empties every stack
        next_cycle(); rst = 1;
        csr_read(PM, 12'h800, UB, "R1 user ptr after reset");
        csr_read(PM, 12'h900, SB, "R1 sup ptr after reset");
        csr_read(PM, 12'h902, SL, "R1 sup limit after reset");
        next_cycle();
        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule